// File: doc/BRIEF.md
# Staged Link Synchronization Controller

This block brings up a group of serial links one alignment level at a time and reports when each link can carry traffic. It runs on the word clock, with one word per cycle. Each word is 34 bit times long: 32 data bits and 2 overhead bits. For every link it reads status from the lower layers: bit lock from clock recovery, a per-word framing verdict from the boundary detector, and received cell-boundary markers. It then steps that link from bit lock to word alignment and, when cell synchronization is enabled, to cell alignment. At that point the link is declared ready.

All links leave reset together and start at the bit-lock stage. After that each link runs on its own. A link error, a loss of bit lock or a run of framing errors sends that link back to the bit-lock stage and sets its sticky error flag. The other links are not affected. A 2-bit mode input picks the role. In the master role the block produces the cell-boundary marker from a shared free-running word counter, and cell alignment locks to that marker. In the slave role it waits for the marker carried in each link's received stream.

Top module: `link_sync_ctrl`

## Requirements
- R1: Each link's stage output uses the encoding 00 bit lock, 01 word alignment, 10 cell alignment, 11 ready. A link leaves stage 00 only for stage 01. Stage 01 is followed only by 10, 11 or a drop to 00. Stage 10 moves only to 11 or 00.
- R2: When `cell_sync_en` is low, a link goes from word alignment straight to ready. A link in stage 10 moves to 11 when a cell marker arrives or when `cell_sync_en` is low.
- R3: A high `link_err[i]` puts link i in stage 00 on the next cycle and sets its error flag. Every other link keeps its stage.
- R4: In the master role `tx_cell_mark` pulses for one cycle every CELL_WORDS cycles (default 8), starting at the first cycle after reset. In the slave role it stays low.
- R5: `mode_sel` = 11 selects the master role. 00, 01 and 10 select the slave role, where cell alignment waits for `rx_cell_mark[i]`. In the master role cell alignment waits for `tx_cell_mark`.
- R6: In stage 01 a link counts consecutive words that have `frame_vld` and `frame_good` both high. It leaves the stage when the count reaches the alignment threshold. A bad framed word sets the count back to zero. An `align_thr` value of 0 selects the default of 4.
- R7: In stages 10 and 11 a link counts consecutive words that have `frame_vld` high and `frame_good` low. It drops to stage 00 and sets its error flag when the count reaches the loss threshold. A good framed word clears the count. A `loss_thr` value of 0 selects the default of 4.
- R8: `err_flag[i]` stays high until `err_clr[i]` is pulsed. If a new error and the clear arrive in the same cycle, the flag stays set.
- R9: While `bit_lock[i]` is low, link i is held in stage 00. A loss of lock from any later stage also sets its error flag.
- R10: During reset every link is in stage 00 with `link_ready` and `err_flag` low. `link_ready[i]` is high exactly when link i is in stage 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Role select: 11 master, otherwise slave |
| cell_sync_en | input | 1 | Enables the cell-alignment stage |
| align_thr | input | THR_W | Good words needed for word alignment (0 means 4) |
| loss_thr | input | THR_W | Bad words that cause loss of alignment (0 means 4) |
| bit_lock | input | NUM_LINKS | Clock-recovery lock, per link |
| frame_vld | input | NUM_LINKS | A framing verdict is present this cycle, per link |
| frame_good | input | NUM_LINKS | Verdict is a correctly framed word, per link |
| rx_cell_mark | input | NUM_LINKS | Received cell-boundary marker, per link |
| link_err | input | NUM_LINKS | Link error, per link |
| err_clr | input | NUM_LINKS | Write-one-to-clear for the error flag, per link |
| tx_cell_mark | output | 1 | Generated cell-boundary marker (master role) |
| link_ready | output | NUM_LINKS | Link fully synchronized |
| err_flag | output | NUM_LINKS | Sticky error flag |
| stage | output | 2*NUM_LINKS | Per-link stage, link i in bits [2i+1:2i] |

## Verification
The assertions check the stage ordering on every cycle. They also check that the cell stage is never entered while it is disabled, and that a link error or lock loss forces bit-lock stage on the next cycle. Further per-cycle checks cover the flag being set on a link error, marker spacing, and the marker staying low in the slave role. Counting is covered only by the bench scenarios: the exact word on which alignment is declared or lost, the default used for a zero threshold, set-over-clear priority, and whether a drop leaves the other link alone. The bench runs a per-cycle reference model next to the design for these cases.

// File: rtl/lsc_pkg.sv
// Shared types and constants for the link synchronization controller.
// Assumes a two-bit stage code that is visible at the block's ports.
package lsc_pkg;
    typedef enum logic [1:0] {
        ST_BIT   = 2'b00,
        ST_WORD  = 2'b01,
        ST_CELL  = 2'b10,
        ST_READY = 2'b11
    } lsc_stage_e;

    localparam int unsigned DEF_THR = 4;
endpackage

// File: rtl/lsc_role_decode.sv
// Role decoder: turns the 2-bit mode into the master/slave role and
// resolves a zero threshold to the default.
// Assumes the mode is quasi-static. Only the point-to-point master code
// (2'b11) gives the master role. Every switch-attached code is slave.
module lsc_role_decode #(
    parameter int unsigned THR_W = 4
) (
    input  logic [1:0]       mode_sel,
    input  logic [THR_W-1:0] align_thr,
    input  logic [THR_W-1:0] loss_thr,
    output logic             is_master,
    output logic [THR_W:0]   align_eff,
    output logic [THR_W:0]   loss_eff
);
    import lsc_pkg::*;

    localparam logic [THR_W:0] DEF_V = (THR_W+1)'(DEF_THR);

    // Role and threshold resolution
    always_comb begin
        is_master = (mode_sel == 2'b11);
        align_eff = (align_thr == '0) ? DEF_V : {1'b0, align_thr};
        loss_eff  = (loss_thr  == '0) ? DEF_V : {1'b0, loss_thr};
    end
endmodule

// File: rtl/lsc_cell_marker_gen.sv
// Cell-boundary marker generator for the master role.
// A free-running word counter gives one marker every CELL_WORDS words.
// The counter is shared by all links so that they see one cell timebase.
// Assumes CELL_WORDS >= 2.
module lsc_cell_marker_gen #(
    parameter int unsigned CELL_WORDS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    output logic tx_cell_mark
);
    localparam int unsigned CW = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CELL_WORDS - 1);

    logic [CW-1:0] cnt_q;

    // Word counter that wraps every CELL_WORDS cycles
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // Marker on the first word of each cell, master role only
    always_comb tx_cell_mark = is_master && (cnt_q == '0);

    AST_MARK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cell_mark |=> !tx_cell_mark); // R4
endmodule

// File: rtl/lsc_lane_fsm.sv
// Per-link synchronization state machine.
// Stages: bit lock -> word alignment -> (optional) cell alignment -> ready.
// Keeps a good-word run counter, a bad-word run counter and a sticky
// error flag. Assumes the thresholds arrive already resolved (nonzero).
module lsc_lane_fsm #(
    parameter int unsigned THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_en_i,
    input  logic [THR_W:0]   align_i,
    input  logic [THR_W:0]   loss_i,
    input  logic             bit_lock_i,
    input  logic             frame_vld_i,
    input  logic             frame_good_i,
    input  logic             cell_mark_i,
    input  logic             link_err_i,
    input  logic             err_clr_i,
    output logic [1:0]       stage_o,
    output logic             ready_o,
    output logic             err_o
);
    import lsc_pkg::*;

    lsc_stage_e       st_q, st_d;
    logic [THR_W-1:0] gc_q, gc_d, bc_q, bc_d;
    logic [THR_W:0]   gc_inc, bc_inc;
    logic             fall, err_q;

    // Next-stage and run-counter logic
    always_comb begin
        st_d   = st_q;
        gc_d   = gc_q;
        bc_d   = bc_q;
        fall   = 1'b0;
        gc_inc = {1'b0, gc_q} + 1'b1;
        bc_inc = {1'b0, bc_q} + 1'b1;
        if (link_err_i || !bit_lock_i) begin
            st_d = ST_BIT;
            gc_d = '0;
            bc_d = '0;
            fall = link_err_i || (st_q != ST_BIT);
        end else begin
            unique case (st_q)
                ST_BIT: st_d = ST_WORD;
                ST_WORD: begin
                    if (frame_vld_i) begin
                        if (!frame_good_i) begin
                            gc_d = '0;
                        end else if (gc_inc >= align_i) begin
                            gc_d = '0;
                            st_d = cell_en_i ? ST_CELL : ST_READY;
                        end else begin
                            gc_d = gc_inc[THR_W-1:0];
                        end
                    end
                end
                default: begin
                    if (frame_vld_i && !frame_good_i) begin
                        if (bc_inc >= loss_i) begin
                            bc_d = '0;
                            st_d = ST_BIT;
                            fall = 1'b1;
                        end else begin
                            bc_d = bc_inc[THR_W-1:0];
                        end
                    end else if (frame_vld_i) begin
                        bc_d = '0;
                    end
                    if (st_q == ST_CELL && !fall && (cell_mark_i || !cell_en_i))
                        st_d = ST_READY;
                end
            endcase
        end
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_BIT;
            gc_q <= '0;
            bc_q <= '0;
        end else begin
            st_q <= st_d;
            gc_q <= gc_d;
            bc_q <= bc_d;
        end
    end

    // Sticky error flag; a new error wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (fall)      err_q <= 1'b1;
        else if (err_clr_i) err_q <= 1'b0;
    end

    // Output mapping
    always_comb begin
        stage_o = st_q;
        ready_o = (st_q == ST_READY);
        err_o   = err_q;
    end

    AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BIT) |=> (st_q == ST_BIT || st_q == ST_WORD)); // R1
    AST_CELL_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CELL) |=> (st_q != ST_WORD)); // R1
    AST_CELL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WORD && !cell_en_i) |=> (st_q != ST_CELL)); // R2
    AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        link_err_i |=> (st_q == ST_BIT && err_q)); // R3
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_lock_i |=> (st_q == ST_BIT)); // R9
    AST_READY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY) |-> $past(bit_lock_i)); // R9
endmodule

// File: rtl/link_sync_ctrl.sv
// Staged link synchronization controller, top level.
// One lane state machine per link, plus a shared role decoder and a
// shared cell-marker generator. All links reset together. After reset
// each lane runs on its own, so an error on one link leaves the others alone.
module link_sync_ctrl #(
    parameter int unsigned NUM_LINKS  = 2,
    parameter int unsigned THR_W      = 4,
    parameter int unsigned CELL_WORDS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode_sel,
    input  logic                   cell_sync_en,
    input  logic [THR_W-1:0]       align_thr,
    input  logic [THR_W-1:0]       loss_thr,
    input  logic [NUM_LINKS-1:0]   bit_lock,
    input  logic [NUM_LINKS-1:0]   frame_vld,
    input  logic [NUM_LINKS-1:0]   frame_good,
    input  logic [NUM_LINKS-1:0]   rx_cell_mark,
    input  logic [NUM_LINKS-1:0]   link_err,
    input  logic [NUM_LINKS-1:0]   err_clr,
    output logic                   tx_cell_mark,
    output logic [NUM_LINKS-1:0]   link_ready,
    output logic [NUM_LINKS-1:0]   err_flag,
    output logic [2*NUM_LINKS-1:0] stage
);
    logic           is_master;
    logic [THR_W:0] align_eff, loss_eff;

    lsc_role_decode #(.THR_W(THR_W)) u_role (
        .mode_sel  (mode_sel),
        .align_thr (align_thr),
        .loss_thr  (loss_thr),
        .is_master (is_master),
        .align_eff (align_eff),
        .loss_eff  (loss_eff)
    );

    lsc_cell_marker_gen #(.CELL_WORDS(CELL_WORDS)) u_mark (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_master    (is_master),
        .tx_cell_mark (tx_cell_mark)
    );

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_lane
        logic cell_src;
        // Cell marker source: own timebase as master, received stream as slave
        always_comb cell_src = is_master ? tx_cell_mark : rx_cell_mark[i];

        lsc_lane_fsm #(.THR_W(THR_W)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .cell_en_i    (cell_sync_en),
            .align_i      (align_eff),
            .loss_i       (loss_eff),
            .bit_lock_i   (bit_lock[i]),
            .frame_vld_i  (frame_vld[i]),
            .frame_good_i (frame_good[i]),
            .cell_mark_i  (cell_src),
            .link_err_i   (link_err[i]),
            .err_clr_i    (err_clr[i]),
            .stage_o      (stage[2*i +: 2]),
            .ready_o      (link_ready[i]),
            .err_o        (err_flag[i])
        );
    end

    AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b11) |-> !tx_cell_mark); // R5
endmodule

// File: tb/sim_link_sync_ctrl.sv
module sim_link_sync_ctrl;
    localparam int NL = 2;
    localparam int TW = 4;
    localparam int CWD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic cell_sync_en = 1'b0;
    logic [TW-1:0] align_thr = '0, loss_thr = '0;
    logic [NL-1:0] bit_lock = '0, frame_vld = '0, frame_good = '0;
    logic [NL-1:0] rx_cell_mark = '0, link_err = '0, err_clr = '0;
    logic tx_cell_mark;
    logic [NL-1:0] link_ready, err_flag;
    logic [2*NL-1:0] stage;

    int n_vec = 0, n_bad = 0, cyc = 0;
    int m_st[NL], m_gc[NL], m_bc[NL], m_er[NL];
    int m_mc = 0;

    link_sync_ctrl #(.NUM_LINKS(NL), .THR_W(TW), .CELL_WORDS(CWD)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cell_sync_en(cell_sync_en),
        .align_thr(align_thr), .loss_thr(loss_thr), .bit_lock(bit_lock),
        .frame_vld(frame_vld), .frame_good(frame_good), .rx_cell_mark(rx_cell_mark),
        .link_err(link_err), .err_clr(err_clr), .tx_cell_mark(tx_cell_mark),
        .link_ready(link_ready), .err_flag(err_flag), .stage(stage)
    );

    always #5 clk = ~clk;

    function automatic int eff(input logic [TW-1:0] t);
        return (t == 0) ? 4 : int'(t);
    endfunction

    function automatic bit exp_mark();
        return (mode_sel == 2'b11) && (m_mc == 0);
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Reference model: advance one clock using the current inputs
    task automatic model_step();
        bit mk = exp_mark();
        for (int i = 0; i < NL; i++) begin
            bit fall = 0;
            if (link_err[i] || !bit_lock[i]) begin
                fall = link_err[i] || (m_st[i] != 0);
                m_st[i] = 0; m_gc[i] = 0; m_bc[i] = 0;
            end else if (m_st[i] == 0) begin
                m_st[i] = 1;
            end else if (m_st[i] == 1) begin
                if (frame_vld[i]) begin
                    if (!frame_good[i]) m_gc[i] = 0;
                    else if (m_gc[i] + 1 >= eff(align_thr)) begin
                        m_gc[i] = 0; m_st[i] = cell_sync_en ? 2 : 3;
                    end else m_gc[i]++;
                end
            end else begin
                bit cm = (mode_sel == 2'b11) ? mk : rx_cell_mark[i];
                int old = m_st[i];
                if (frame_vld[i] && !frame_good[i]) begin
                    if (m_bc[i] + 1 >= eff(loss_thr)) begin
                        m_bc[i] = 0; m_st[i] = 0; fall = 1;
                    end else m_bc[i]++;
                end else if (frame_vld[i]) m_bc[i] = 0;
                if (old == 2 && !fall && (cm || !cell_sync_en)) m_st[i] = 3;
            end
            if (fall) m_er[i] = 1;
            else if (err_clr[i]) m_er[i] = 0;
        end
        m_mc = (m_mc == CWD - 1) ? 0 : m_mc + 1;
    endtask

    // Compare all outputs against the model, then advance one cycle
    task automatic step(input string tag);
        #1;
        for (int i = 0; i < NL; i++) begin
            check_eq({tag, " R1 stage"}, int'(stage[2*i +: 2]), m_st[i]);
            check_eq({tag, " R10 ready"}, int'(link_ready[i]), int'(m_st[i] == 3));
            check_eq({tag, " R8 err"}, int'(err_flag[i]), m_er[i]);
        end
        check_eq({tag, " R4 mark"}, int'(tx_cell_mark), int'(exp_mark()));
        model_step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle_inputs();
        bit_lock = '1; frame_vld = '1; frame_good = '1;
        rx_cell_mark = '0; link_err = '0; err_clr = '0;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_gc[i] = 0; m_bc[i] = 0; m_er[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        check_eq("R10 reset stage", int'(stage), 0);
        check_eq("R10 reset ready", int'(link_ready), 0);
        check_eq("R10 reset err", int'(err_flag), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: default threshold of 4 good words, no cell stage (R2)
        idle_inputs();
        step("R6");                              // BIT -> WORD
        repeat (3) step("R6");                   // three good words
        #1 check_eq("R6 not ready after 3", int'(link_ready), 0);
        step("R6");                              // fourth good word
        #1 check_eq("R2 ready after word align", int'(link_ready), 2'b11);

        // R3: error on link 0 only; link 1 stays ready
        link_err = 2'b01;
        step("R3");
        link_err = '0;
        #1 check_eq("R3 link0 dropped", int'(stage[1:0]), 0);
        check_eq("R3 link1 untouched", int'(stage[3:2]), 3);
        check_eq("R3 err set", int'(err_flag), 2'b01);

        // R8: clear and a new error in the same cycle keeps the flag
        link_err = 2'b01; err_clr = 2'b01;
        step("R8");
        link_err = '0; err_clr = '0;
        #1 check_eq("R8 set beats clear", int'(err_flag[0]), 1);
        err_clr = 2'b01;
        step("R8");
        err_clr = '0;
        #1 check_eq("R8 cleared", int'(err_flag[0]), 0);

        // R7: loss threshold 2 on link 1
        loss_thr = 4'd2;
        frame_good = 2'b01;
        step("R7");
        #1 check_eq("R7 one bad word", int'(stage[3:2]), 3);
        step("R7");
        frame_good = '1;
        #1 check_eq("R7 dropped after 2", int'(stage[3:2]), 0);
        check_eq("R7 err", int'(err_flag[1]), 1);

        // R5/R4: master role with cell sync
        mode_sel = 2'b11; cell_sync_en = 1'b1; link_err = '1;
        step("R5");
        link_err = '0; err_clr = '1;
        repeat (20) step("R5 master");
        err_clr = '0;
        #1 check_eq("R5 master ready", int'(link_ready), 2'b11);

        // R9: lock loss holds bit stage
        bit_lock = 2'b10;
        repeat (3) step("R9");
        #1 check_eq("R9 held", int'(stage[1:0]), 0);
        bit_lock = '1;

        // Random phase checked by model
        for (int k = 0; k < 6000; k++) begin
            if (k % 400 == 0) begin
                mode_sel = 2'($urandom_range(0, 3));
                cell_sync_en = 1'($urandom_range(0, 1));
                align_thr = TW'($urandom_range(0, 5));
                loss_thr = TW'($urandom_range(0, 5));
            end
            for (int i = 0; i < NL; i++) begin
                bit_lock[i]     = ($urandom_range(0, 99) < 98);
                link_err[i]     = ($urandom_range(0, 99) < 1);
                frame_vld[i]    = ($urandom_range(0, 99) < 70);
                frame_good[i]   = ($urandom_range(0, 99) < 85);
                rx_cell_mark[i] = ($urandom_range(0, 99) < 15);
                err_clr[i]      = ($urandom_range(0, 99) < 5);
            end
            step("R1 R2 R5 R6 R7 R9 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule